// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block decides, for the execute stage of a five-stage 32-bit pipeline, where each ALU operand and the store-data value should come from. It compares the execute-stage source register tags against the destination tags of the two younger-result stages, memory-stage and write-back-stage. It uses each producer's register-write flag and its write-back kind. From these it picks among eight operand sources: the register file value, the memory-stage ALU result, the final write-back data, the execute-stage PC or immediate, the link address (PC plus four) of either later stage, or the immediate of either later stage.

Two execute-stage flags override forwarding. The first marks a PC-relative upper-immediate add, which takes the execute PC as operand A. The second marks an instruction whose second ALU operand is its immediate, which takes the execute immediate as operand B. Store data has its own three-way selector, so a store whose ALU operand B is the immediate still receives a forwarded rs2 value. The block is purely combinational. It contains the eight-way and four-way data muxes so that the selects and the selected values can be checked together at its ports. The ALU is outside this block.

Top module: `opfwd_unit`

## Requirements
- R1: Operand-A select codes are 0 rs1 register value, 1 memory-stage ALU result, 2 write-back data, 3 execute PC, 4 memory-stage PC+4, 5 write-back-stage PC+4, 6 memory-stage immediate, 7 write-back-stage immediate. `opnd_a` always equals the source named by `sel_a`.
- R2: Operand-B select codes match R1, with two differences: code 0 is the rs2 register value and code 3 is the execute immediate. `opnd_b` always equals the source named by `sel_b`.
- R3: When `ex_is_auipc` is 1, `sel_a` is 3. When `ex_use_imm` is 1, `sel_b` is 3. This holds whatever the stage tags match.
- R4: Write-back kind encoding is 0 ALU result, 1 memory data, 2 link (PC+4), 3 immediate. A memory-stage hit gives 1 for ALU, 4 for link and 6 for immediate. A write-back-stage hit gives 2 for ALU or memory data, 5 for link and 7 for immediate.
- R5: A stage only hits when its register-write flag is 1 and its destination tag equals the source tag.
- R6: A destination tag of 0 never forwards. An operand whose source tag is 0 keeps code 0 unless R3 applies.
- R7: When both stages hit the same source tag, the memory stage wins.
- R8: A memory-stage hit of kind 1 (load) is ignored. The write-back stage is then considered as if the memory stage had not matched.
- R9: Store-data select codes are 0 rs2 register value, 1 memory-stage ALU result, 2 write-back data. A memory-stage hit of kind 0 gives 1. Otherwise any write-back-stage hit gives 2, and otherwise the code is 0. `ex_use_imm` does not affect it, and `store_data` equals the selected source.
- R10: A link source value is that stage's PC plus `LINK_BYTES` (4 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_tag | input | TAG_W | Execute-stage first source register tag |
| ex_rs2_tag | input | TAG_W | Execute-stage second source register tag |
| ex_is_auipc | input | 1 | Execute instruction adds an upper immediate to its PC |
| ex_use_imm | input | 1 | Execute instruction uses its immediate as ALU operand B |
| ex_rs1_val | input | DATA_W | Register file value for rs1 |
| ex_rs2_val | input | DATA_W | Register file value for rs2 |
| ex_pc | input | DATA_W | Execute-stage PC |
| ex_imm | input | DATA_W | Execute-stage immediate |
| mem_rd_tag | input | TAG_W | Memory-stage destination tag |
| mem_wen | input | 1 | Memory-stage register-write flag |
| mem_kind | input | 2 | Memory-stage write-back kind |
| mem_alu_res | input | DATA_W | Memory-stage ALU result |
| mem_pc | input | DATA_W | Memory-stage PC |
| mem_imm | input | DATA_W | Memory-stage immediate |
| wb_rd_tag | input | TAG_W | Write-back-stage destination tag |
| wb_wen | input | 1 | Write-back-stage register-write flag |
| wb_kind | input | 2 | Write-back-stage write-back kind |
| wb_pc | input | DATA_W | Write-back-stage PC |
| wb_imm | input | DATA_W | Write-back-stage immediate |
| wb_data | input | DATA_W | Final write-back data |
| sel_a | output | 3 | Operand-A source code |
| sel_b | output | 3 | Operand-B source code |
| sel_st | output | 2 | Store-data source code |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |
| store_data | output | DATA_W | Selected store data |

## Verification
The bench builds the block with its defaults: 32-bit data, 5-bit tags and a link offset of 4. With 5-bit tags, both the x0 case and the highest tag 31 can be reached. Every source value is a distinct constant, so each of the eight operand codes and the three store codes can be told apart from the data outputs alone. The link-offset arithmetic shows directly as PC+4 on the operand outputs.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    // write-back kind of a producing instruction
    typedef enum logic [1:0] {
        WBK_ALU  = 2'd0,
        WBK_LOAD = 2'd1,
        WBK_LINK = 2'd2,
        WBK_IMM  = 2'd3
    } wb_kind_e;

    // operand source codes (code 3 is the execute stage's own value)
    typedef enum logic [2:0] {
        OPS_REG     = 3'd0,
        OPS_MEM_ALU = 3'd1,
        OPS_WB_DATA = 3'd2,
        OPS_OWN     = 3'd3,
        OPS_MEM_LNK = 3'd4,
        OPS_WB_LNK  = 3'd5,
        OPS_MEM_IMM = 3'd6,
        OPS_WB_IMM  = 3'd7
    } op_src_e;

    // store-data source codes
    typedef enum logic [1:0] {
        STS_REG     = 2'd0,
        STS_MEM_ALU = 2'd1,
        STS_WB_DATA = 2'd2,
        STS_ZERO    = 2'd3
    } st_src_e;

    typedef struct packed {
        logic    mem_hit;
        logic    wb_hit;
        op_src_e sel;
    } op_pick_t;

    typedef struct packed {
        logic    mem_hit;
        logic    wb_hit;
        st_src_e sel;
    } st_pick_t;

endpackage

// File: rtl/opfwd_pick.sv
module opfwd_pick
    import opfwd_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic [TAG_W-1:0] src_tag,
    input  logic             own_ovr,
    input  logic [TAG_W-1:0] mem_rd_tag,
    input  logic             mem_wen,
    input  logic [1:0]       mem_kind,
    input  logic [TAG_W-1:0] wb_rd_tag,
    input  logic             wb_wen,
    input  logic [1:0]       wb_kind,
    output logic [2:0]       sel
);

    localparam logic [TAG_W-1:0] ZERO_TAG = '0;

    op_pick_t pick_d;

    always_comb begin
        pick_d = '{mem_hit: 1'b0, wb_hit: 1'b0, sel: OPS_REG};
        // load results never come from the memory stage
        pick_d.mem_hit = mem_wen && (mem_rd_tag != ZERO_TAG)
                      && (mem_rd_tag == src_tag)
                      && (mem_kind != WBK_LOAD);
        pick_d.wb_hit  = wb_wen && (wb_rd_tag != ZERO_TAG)
                      && (wb_rd_tag == src_tag);
        if (own_ovr) begin
            pick_d.sel = OPS_OWN;
        end else if (pick_d.mem_hit) begin
            unique case (mem_kind)
                WBK_LINK: pick_d.sel = OPS_MEM_LNK;
                WBK_IMM:  pick_d.sel = OPS_MEM_IMM;
                default:  pick_d.sel = OPS_MEM_ALU;
            endcase
        end else if (pick_d.wb_hit) begin
            unique case (wb_kind)
                WBK_LINK: pick_d.sel = OPS_WB_LNK;
                WBK_IMM:  pick_d.sel = OPS_WB_IMM;
                default:  pick_d.sel = OPS_WB_DATA;
            endcase
        end
    end

    assign sel = pick_d.sel;

    always_comb begin
        if (own_ovr)
            assert_override_R3: assert (sel == 3'd3);
        if (!own_ovr && src_tag == ZERO_TAG)
            assert_x0_quiet_R6: assert (sel == 3'd0);
        if (!own_ovr && mem_kind == 2'd1 && mem_rd_tag == src_tag)
            assert_no_mem_load_R8: assert (sel != 3'd1 && sel != 3'd4 && sel != 3'd6);
        if (!own_ovr && !mem_wen && !wb_wen)
            assert_need_wen_R5: assert (sel == 3'd0);
    end

endmodule

// File: rtl/opfwd_store_pick.sv
module opfwd_store_pick
    import opfwd_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic [TAG_W-1:0] src_tag,
    input  logic [TAG_W-1:0] mem_rd_tag,
    input  logic             mem_wen,
    input  logic [1:0]       mem_kind,
    input  logic [TAG_W-1:0] wb_rd_tag,
    input  logic             wb_wen,
    output logic [1:0]       sel
);

    localparam logic [TAG_W-1:0] ZERO_TAG = '0;

    st_pick_t pick_d;

    always_comb begin
        pick_d = '{mem_hit: 1'b0, wb_hit: 1'b0, sel: STS_REG};
        pick_d.mem_hit = mem_wen && (mem_rd_tag != ZERO_TAG)
                      && (mem_rd_tag == src_tag)
                      && (mem_kind == WBK_ALU);
        pick_d.wb_hit  = wb_wen && (wb_rd_tag != ZERO_TAG)
                      && (wb_rd_tag == src_tag);
        if (pick_d.mem_hit)
            pick_d.sel = STS_MEM_ALU;
        else if (pick_d.wb_hit)
            pick_d.sel = STS_WB_DATA;
    end

    assign sel = pick_d.sel;

    always_comb begin
        assert_st_code_R9: assert (sel != 2'd3);
        if (src_tag == ZERO_TAG)
            assert_st_x0_R6: assert (sel == 2'd0);
    end

endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux #(
    parameter int W    = 32,
    parameter int N_IN = 8,
    localparam int SEL_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0][W-1:0] src,
    input  logic [SEL_W-1:0]       sel,
    output logic [W-1:0]           dout
);

    always_comb begin
        dout = src[sel];
    end

endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int TAG_W      = 5,
    parameter int LINK_BYTES = 4
) (
    input  logic [TAG_W-1:0]  ex_rs1_tag,
    input  logic [TAG_W-1:0]  ex_rs2_tag,
    input  logic              ex_is_auipc,
    input  logic              ex_use_imm,
    input  logic [DATA_W-1:0] ex_rs1_val,
    input  logic [DATA_W-1:0] ex_rs2_val,
    input  logic [DATA_W-1:0] ex_pc,
    input  logic [DATA_W-1:0] ex_imm,
    input  logic [TAG_W-1:0]  mem_rd_tag,
    input  logic              mem_wen,
    input  logic [1:0]        mem_kind,
    input  logic [DATA_W-1:0] mem_alu_res,
    input  logic [DATA_W-1:0] mem_pc,
    input  logic [DATA_W-1:0] mem_imm,
    input  logic [TAG_W-1:0]  wb_rd_tag,
    input  logic              wb_wen,
    input  logic [1:0]        wb_kind,
    input  logic [DATA_W-1:0] wb_pc,
    input  logic [DATA_W-1:0] wb_imm,
    input  logic [DATA_W-1:0] wb_data,
    output logic [2:0]        sel_a,
    output logic [2:0]        sel_b,
    output logic [1:0]        sel_st,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] store_data
);

    localparam int N_OPND = 2;
    localparam int N_OPS  = 8;
    localparam int N_STS  = 4;
    localparam logic [DATA_W-1:0] LINK_ADD = DATA_W'(LINK_BYTES);

    logic [DATA_W-1:0] mem_link_d, wb_link_d;
    logic [TAG_W-1:0]  op_tag_d  [N_OPND];
    logic              op_ovr_d  [N_OPND];
    logic [DATA_W-1:0] op_reg_d  [N_OPND];
    logic [DATA_W-1:0] op_own_d  [N_OPND];
    logic [2:0]        op_sel_d  [N_OPND];
    logic [DATA_W-1:0] op_val_d  [N_OPND];
    logic [N_STS-1:0][DATA_W-1:0] st_src_d;

    always_comb begin
        mem_link_d  = mem_pc + LINK_ADD;
        wb_link_d   = wb_pc + LINK_ADD;
        op_tag_d[0] = ex_rs1_tag;
        op_tag_d[1] = ex_rs2_tag;
        op_ovr_d[0] = ex_is_auipc;
        op_ovr_d[1] = ex_use_imm;
        op_reg_d[0] = ex_rs1_val;
        op_reg_d[1] = ex_rs2_val;
        op_own_d[0] = ex_pc;
        op_own_d[1] = ex_imm;
        st_src_d[STS_REG]     = ex_rs2_val;
        st_src_d[STS_MEM_ALU] = mem_alu_res;
        st_src_d[STS_WB_DATA] = wb_data;
        st_src_d[STS_ZERO]    = '0;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        logic [N_OPS-1:0][DATA_W-1:0] src_d;

        always_comb begin
            src_d[OPS_REG]     = op_reg_d[g];
            src_d[OPS_MEM_ALU] = mem_alu_res;
            src_d[OPS_WB_DATA] = wb_data;
            src_d[OPS_OWN]     = op_own_d[g];
            src_d[OPS_MEM_LNK] = mem_link_d;
            src_d[OPS_WB_LNK]  = wb_link_d;
            src_d[OPS_MEM_IMM] = mem_imm;
            src_d[OPS_WB_IMM]  = wb_imm;
        end

        opfwd_pick #(.TAG_W(TAG_W)) u_pick (
            .src_tag    (op_tag_d[g]),
            .own_ovr    (op_ovr_d[g]),
            .mem_rd_tag (mem_rd_tag),
            .mem_wen    (mem_wen),
            .mem_kind   (mem_kind),
            .wb_rd_tag  (wb_rd_tag),
            .wb_wen     (wb_wen),
            .wb_kind    (wb_kind),
            .sel        (op_sel_d[g])
        );

        opfwd_mux #(.W(DATA_W), .N_IN(N_OPS)) u_mux (
            .src  (src_d),
            .sel  (op_sel_d[g]),
            .dout (op_val_d[g])
        );
    end

    opfwd_store_pick #(.TAG_W(TAG_W)) u_st_pick (
        .src_tag    (ex_rs2_tag),
        .mem_rd_tag (mem_rd_tag),
        .mem_wen    (mem_wen),
        .mem_kind   (mem_kind),
        .wb_rd_tag  (wb_rd_tag),
        .wb_wen     (wb_wen),
        .sel        (sel_st)
    );

    opfwd_mux #(.W(DATA_W), .N_IN(N_STS)) u_st_mux (
        .src  (st_src_d),
        .sel  (sel_st),
        .dout (store_data)
    );

    assign sel_a  = op_sel_d[0];
    assign sel_b  = op_sel_d[1];
    assign opnd_a = op_val_d[0];
    assign opnd_b = op_val_d[1];

    always_comb begin
        if (sel_a == 3'd4)
            assert_link_value_R10: assert (opnd_a == mem_pc + LINK_ADD);
        if (sel_a == 3'd3)
            assert_a_own_pc_R1: assert (opnd_a == ex_pc);
        if (sel_b == 3'd3)
            assert_b_own_imm_R2: assert (opnd_b == ex_imm);
        if (mem_wen && mem_kind == 2'd0 && mem_rd_tag != '0 && mem_rd_tag == ex_rs1_tag && !ex_is_auipc)
            assert_mem_first_R7: assert (sel_a == 3'd1);
    end

endmodule

// File: tb/opfwd_unit_test.sv
`timescale 1ns/1ps
module opfwd_unit_test;

    localparam int DW = 32;
    localparam int TW = 5;

    localparam logic [DW-1:0] V_RS1  = 32'h1111_1111;
    localparam logic [DW-1:0] V_RS2  = 32'h2222_2222;
    localparam logic [DW-1:0] V_PC   = 32'h0000_1000;
    localparam logic [DW-1:0] V_IMM  = 32'h0000_0033;
    localparam logic [DW-1:0] V_MALU = 32'hAAAA_0001;
    localparam logic [DW-1:0] V_MPC  = 32'h0000_2000;
    localparam logic [DW-1:0] V_MIMM = 32'h0004_4000;
    localparam logic [DW-1:0] V_WPC  = 32'h0000_3000;
    localparam logic [DW-1:0] V_WIMM = 32'h0005_5000;
    localparam logic [DW-1:0] V_WDAT = 32'hBBBB_0002;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [TW-1:0] ex_rs1_tag, ex_rs2_tag, mem_rd_tag, wb_rd_tag;
    logic ex_is_auipc, ex_use_imm, mem_wen, wb_wen;
    logic [1:0] mem_kind, wb_kind;
    logic [2:0] sel_a, sel_b;
    logic [1:0] sel_st;
    logic [DW-1:0] opnd_a, opnd_b, store_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    opfwd_unit #(.DATA_W(DW), .TAG_W(TW), .LINK_BYTES(4)) uut (
        .ex_rs1_tag(ex_rs1_tag), .ex_rs2_tag(ex_rs2_tag),
        .ex_is_auipc(ex_is_auipc), .ex_use_imm(ex_use_imm),
        .ex_rs1_val(V_RS1), .ex_rs2_val(V_RS2), .ex_pc(V_PC), .ex_imm(V_IMM),
        .mem_rd_tag(mem_rd_tag), .mem_wen(mem_wen), .mem_kind(mem_kind),
        .mem_alu_res(V_MALU), .mem_pc(V_MPC), .mem_imm(V_MIMM),
        .wb_rd_tag(wb_rd_tag), .wb_wen(wb_wen), .wb_kind(wb_kind),
        .wb_pc(V_WPC), .wb_imm(V_WIMM), .wb_data(V_WDAT),
        .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .store_data(store_data)
    );

    // expected operand value from the R1/R2/R10 encodings
    function automatic logic [DW-1:0] op_val(input logic [2:0] code, input bit is_b);
        case (code)
            3'd0: op_val = is_b ? V_RS2 : V_RS1;
            3'd1: op_val = V_MALU;
            3'd2: op_val = V_WDAT;
            3'd3: op_val = is_b ? V_IMM : V_PC;
            3'd4: op_val = V_MPC + 32'd4;
            3'd5: op_val = V_WPC + 32'd4;
            3'd6: op_val = V_MIMM;
            default: op_val = V_WIMM;
        endcase
    endfunction

    function automatic logic [DW-1:0] st_val(input logic [1:0] code);
        case (code)
            2'd0: st_val = V_RS2;
            2'd1: st_val = V_MALU;
            2'd2: st_val = V_WDAT;
            default: st_val = '0;
        endcase
    endfunction

    task automatic idle();
        ex_rs1_tag = '0; ex_rs2_tag = '0; ex_is_auipc = 0; ex_use_imm = 0;
        mem_rd_tag = '0; mem_wen = 0; mem_kind = 2'd0;
        wb_rd_tag  = '0; wb_wen  = 0; wb_kind  = 2'd0;
    endtask

    task automatic expect_all(input logic [2:0] ea, input logic [2:0] eb,
                              input logic [1:0] es, input string req);
        @(negedge clk);
        #1;
        n_run++;
        if (sel_a !== ea || opnd_a !== op_val(ea, 0)) begin
            n_fail++;
            $display("FAIL %s operand A: sel=%0d val=%h expected sel=%0d val=%h",
                     req, sel_a, opnd_a, ea, op_val(ea, 0));
        end
        n_run++;
        if (sel_b !== eb || opnd_b !== op_val(eb, 1)) begin
            n_fail++;
            $display("FAIL %s operand B: sel=%0d val=%h expected sel=%0d val=%h",
                     req, sel_b, opnd_b, eb, op_val(eb, 1));
        end
        n_run++;
        if (sel_st !== es || store_data !== st_val(es)) begin
            n_fail++;
            $display("FAIL %s store: sel=%0d val=%h expected sel=%0d val=%h",
                     req, sel_st, store_data, es, st_val(es));
        end
    endtask

    task automatic t_reset_state();
        idle();
        expect_all(3'd0, 3'd0, 2'd0, "R5 idle");
        ex_rs1_tag = 5'd3; ex_rs2_tag = 5'd4;
        expect_all(3'd0, 3'd0, 2'd0, "R1 no producers");
    endtask

    task automatic t_mem_kinds();
        idle();
        ex_rs1_tag = 5'd7; ex_rs2_tag = 5'd7;
        mem_rd_tag = 5'd7; mem_wen = 1;
        mem_kind = 2'd0; expect_all(3'd1, 3'd1, 2'd1, "R4 mem alu");
        mem_kind = 2'd2; expect_all(3'd4, 3'd4, 2'd0, "R10 mem link");
        mem_kind = 2'd3; expect_all(3'd6, 3'd6, 2'd0, "R4 mem imm");
    endtask

    task automatic t_wb_kinds();
        idle();
        ex_rs1_tag = 5'd31; ex_rs2_tag = 5'd31;
        wb_rd_tag = 5'd31; wb_wen = 1;
        wb_kind = 2'd0; expect_all(3'd2, 3'd2, 2'd2, "R4 wb alu");
        wb_kind = 2'd1; expect_all(3'd2, 3'd2, 2'd2, "R4 wb load");
        wb_kind = 2'd2; expect_all(3'd5, 3'd5, 2'd2, "R10 wb link");
        wb_kind = 2'd3; expect_all(3'd7, 3'd7, 2'd2, "R4 wb imm");
    endtask

    task automatic t_overrides();
        idle();
        ex_rs1_tag = 5'd9; ex_rs2_tag = 5'd9;
        mem_rd_tag = 5'd9; mem_wen = 1; mem_kind = 2'd0;
        ex_is_auipc = 1; expect_all(3'd3, 3'd1, 2'd1, "R3 auipc");
        ex_is_auipc = 0; ex_use_imm = 1;
        expect_all(3'd1, 3'd3, 2'd1, "R9 use_imm keeps store fwd");
        ex_is_auipc = 1; expect_all(3'd3, 3'd3, 2'd1, "R2 both own");
    endtask

    task automatic t_priority();
        idle();
        ex_rs1_tag = 5'd12; ex_rs2_tag = 5'd12;
        mem_rd_tag = 5'd12; mem_wen = 1; mem_kind = 2'd3;
        wb_rd_tag  = 5'd12; wb_wen  = 1; wb_kind  = 2'd0;
        expect_all(3'd6, 3'd6, 2'd2, "R7 mem over wb");
        ex_rs2_tag = 5'd13; wb_rd_tag = 5'd13;
        expect_all(3'd6, 3'd2, 2'd2, "R7 split tags");
    endtask

    task automatic t_x0();
        idle();
        mem_wen = 1; mem_kind = 2'd0;
        wb_wen = 1; wb_kind = 2'd2;
        expect_all(3'd0, 3'd0, 2'd0, "R6 rd zero");
    endtask

    task automatic t_wen();
        idle();
        ex_rs1_tag = 5'd5; ex_rs2_tag = 5'd5;
        mem_rd_tag = 5'd5; mem_kind = 2'd0;
        wb_rd_tag = 5'd5; wb_kind = 2'd0;
        expect_all(3'd0, 3'd0, 2'd0, "R5 wen low");
        mem_rd_tag = 5'd6; mem_wen = 1; wb_rd_tag = 5'd4; wb_wen = 1;
        expect_all(3'd0, 3'd0, 2'd0, "R5 tag mismatch");
    endtask

    task automatic t_load();
        idle();
        ex_rs1_tag = 5'd8; ex_rs2_tag = 5'd8;
        mem_rd_tag = 5'd8; mem_wen = 1; mem_kind = 2'd1;
        expect_all(3'd0, 3'd0, 2'd0, "R8 mem load ignored");
        wb_rd_tag = 5'd8; wb_wen = 1; wb_kind = 2'd3;
        expect_all(3'd7, 3'd7, 2'd2, "R8 falls to wb");
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_mem_kinds();
        t_wb_kinds();
        t_overrides();
        t_priority();
        t_x0();
        t_wen();
        t_load();
        done = 1'b1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: done=0 expected done=1");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule